// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block keeps a small bank of ownership flags that two independent ports, left and right, use to coordinate access to a shared resource. Each port has its own flag select, memory enable, write strobe, flag index and data buses. A port asks for a flag by writing a zero to it. It then checks the outcome in a later, separate read cycle. Writing a one gives the flag back.

Only bit 0 of a write matters. A read returns the reader's view of the flag on every bit of the data bus. A request against a flag that the opposite side holds is kept pending. That request is granted in the same cycle that the holder releases the flag. When both sides request the same free flag in the same cycle, one fixed side wins. The default is the left side. The losing side keeps a pending request. The two sides never own a flag at the same time.

Top module: `dpsem_unit`

## Requirements
- R1: The 3-bit index selects one of eight flags. Each flag is independent, so an access to one index never changes the state or read value of another index.
- R2: A flag write samples only data bit 0. Bit 0 = 0 is a request and bit 0 = 1 is a release. All other data bits are ignored.
- R3: A flag read sets all 16 bits of that port's read data to the same value in the cycle after the read. The value is 0 when the reading side owns the flag and 1 otherwise.
- R4: An access takes effect only when the port's flag select is 1 and its memory enable is 0. Any other strobe leaves all flags and that port's read data unchanged.
- R5: A request is granted in the cycle after the write when the opposite side does not hold the flag.
- R6: A request against a flag that the opposite side holds stays pending. It is granted in the same cycle that the opposite side releases the flag.
- R7: A release frees the flag if the writing side holds it. It also cancels any pending request from that side, so a later release by the other side does not grant the flag to it.
- R8: When both sides request the same free flag in the same cycle, exactly one side wins: left by default. The loser's request stays pending. A flag is never owned by both sides.
- R9: After reset all flags are free, nothing is pending, and both read data buses read all ones.
- R10: The right port behaves exactly like the left port, with the roles of the two sides swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lft_sem_sel | input | 1 | Left flag select, active high |
| lft_mem_en | input | 1 | Left memory enable; when high it blocks flag access |
| lft_wr | input | 1 | Left access type: 1 write, 0 read |
| lft_idx | input | 3 | Left flag index |
| lft_wdata | input | 16 | Left write data; only bit 0 is used |
| lft_rdata | output | 16 | Left read data, registered |
| rgt_sem_sel | input | 1 | Right flag select, active high |
| rgt_mem_en | input | 1 | Right memory enable; when high it blocks flag access |
| rgt_wr | input | 1 | Right access type: 1 write, 0 read |
| rgt_idx | input | 3 | Right flag index |
| rgt_wdata | input | 16 | Right write data; only bit 0 is used |
| rgt_rdata | output | 16 | Right read data, registered |

## Verification
The grant and release properties assume a write lasts exactly one clock with a stable index. They also assume the opposite port is not writing in that cycle when an uncontested grant is being checked. The bench drives every access as a single-cycle pulse and returns both ports to idle afterwards. It reads only in cycles that follow a completed write, so each read sees settled state. The stability property assumes both ports are blocked or idle together. The gating tests therefore hold the opposite port idle while one port strobes with its memory enable high or its select low.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_t;

   typedef struct packed {
      logic own_l;
      logic own_r;
      logic pend_l;
      logic pend_r;
   } flag_state_t;

   localparam flag_state_t FLAG_FREE = '{own_l: 1'b0, own_r: 1'b0, pend_l: 1'b0, pend_r: 1'b0};
endpackage

// File: rtl/dpsem_port_dec.sv
module dpsem_port_dec
   import dpsem_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 16,
   localparam int N_FLAGS = 2 ** IDX_W
) (
   input  logic                sem_sel,
   input  logic                mem_en,
   input  logic                wr,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [N_FLAGS-1:0]  req,
   output logic [N_FLAGS-1:0]  rel,
   output logic                rd_stb
);
   acc_kind_t kind;
   logic      unused_hi;

   always_comb begin
      if (!sem_sel || mem_en) kind = ACC_IDLE;
      else if (wr)            kind = ACC_WRITE;
      else                    kind = ACC_READ;
   end

   assign rd_stb = (kind == ACC_READ);

   generate
      if (DATA_W > 1) begin : g_hi
         assign unused_hi = ^wdata[DATA_W-1:1];
      end else begin : g_nohi
         assign unused_hi = 1'b0;
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < N_FLAGS; gi++) begin : g_sel
         logic hit;
         assign hit     = (kind == ACC_WRITE) && (idx == IDX_W'(gi));
         assign req[gi] = hit && !wdata[0];
         assign rel[gi] = hit &&  wdata[0];
      end
   endgenerate
endmodule

// File: rtl/dpsem_flag_cell.sv
module dpsem_flag_cell
   import dpsem_pkg::*;
#(
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_l,
   input  logic        rel_l,
   input  logic        req_r,
   input  logic        rel_r,
   output flag_state_t st
);
   flag_state_t st_q;
   logic want_l, want_r;
   logic own_l_d, own_r_d;

   assign want_l = (st_q.own_l | st_q.pend_l | req_l) & ~rel_l;
   assign want_r = (st_q.own_r | st_q.pend_r | req_r) & ~rel_r;

   generate
      if (LEFT_WINS) begin : g_left_pri
         always_comb begin
            own_l_d = want_l & ~(st_q.own_r & want_r);
            own_r_d = want_r & ~own_l_d;
         end
      end else begin : g_right_pri
         always_comb begin
            own_r_d = want_r & ~(st_q.own_l & want_l);
            own_l_d = want_l & ~own_r_d;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= FLAG_FREE;
      end else begin
         st_q.own_l  <= own_l_d;
         st_q.own_r  <= own_r_d;
         st_q.pend_l <= want_l & ~own_l_d;
         st_q.pend_r <= want_r & ~own_r_d;
      end
   end

   assign st = st_q;
endmodule

// File: rtl/dpsem_rd_reg.sv
module dpsem_rd_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              owned,
   output logic [DATA_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '1;
      else if (rd_stb) rdata <= {DATA_W{~owned}};
   end
endmodule

// File: rtl/dpsem_unit.sv
module dpsem_unit
   import dpsem_pkg::*;
#(
   parameter int IDX_W     = 3,
   parameter int DATA_W    = 16,
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lft_sem_sel,
   input  logic              lft_mem_en,
   input  logic              lft_wr,
   input  logic [IDX_W-1:0]  lft_idx,
   input  logic [DATA_W-1:0] lft_wdata,
   output logic [DATA_W-1:0] lft_rdata,
   input  logic              rgt_sem_sel,
   input  logic              rgt_mem_en,
   input  logic              rgt_wr,
   input  logic [IDX_W-1:0]  rgt_idx,
   input  logic [DATA_W-1:0] rgt_wdata,
   output logic [DATA_W-1:0] rgt_rdata
);
   localparam int N_FLAGS = 2 ** IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 6) begin : g_bad_idx
         $error("dpsem_unit: IDX_W must lie in 1..6");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dpsem_unit: DATA_W must be at least 1");
      end
   endgenerate

   logic [N_FLAGS-1:0] req_l, rel_l, req_r, rel_r;
   logic [N_FLAGS-1:0] own_l_q, own_r_q, pend_l_q, pend_r_q;
   logic               rd_l, rd_r;

   dpsem_port_dec #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_dec_l (
      .sem_sel (lft_sem_sel),
      .mem_en  (lft_mem_en),
      .wr      (lft_wr),
      .idx     (lft_idx),
      .wdata   (lft_wdata),
      .req     (req_l),
      .rel     (rel_l),
      .rd_stb  (rd_l)
   );

   dpsem_port_dec #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_dec_r (
      .sem_sel (rgt_sem_sel),
      .mem_en  (rgt_mem_en),
      .wr      (rgt_wr),
      .idx     (rgt_idx),
      .wdata   (rgt_wdata),
      .req     (req_r),
      .rel     (rel_r),
      .rd_stb  (rd_r)
   );

   genvar gf;
   generate
      for (gf = 0; gf < N_FLAGS; gf++) begin : g_flag
         flag_state_t st;
         dpsem_flag_cell #(.LEFT_WINS(LEFT_WINS)) i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .req_l (req_l[gf]),
            .rel_l (rel_l[gf]),
            .req_r (req_r[gf]),
            .rel_r (rel_r[gf]),
            .st    (st)
         );
         assign own_l_q[gf]  = st.own_l;
         assign own_r_q[gf]  = st.own_r;
         assign pend_l_q[gf] = st.pend_l;
         assign pend_r_q[gf] = st.pend_r;
      end
   endgenerate

   dpsem_rd_reg #(.DATA_W(DATA_W)) i_rd_l (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_stb (rd_l),
      .owned  (own_l_q[lft_idx]),
      .rdata  (lft_rdata)
   );

   dpsem_rd_reg #(.DATA_W(DATA_W)) i_rd_r (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_stb (rd_r),
      .owned  (own_r_q[rgt_idx]),
      .rdata  (rgt_rdata)
   );
endmodule

// File: rtl/dpsem_chk.sv
module dpsem_chk #(
   parameter int IDX_W     = 3,
   parameter int DATA_W    = 16,
   parameter bit LEFT_WINS = 1'b1,
   localparam int N_FLAGS  = 2 ** IDX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lft_sem_sel,
   input logic              lft_mem_en,
   input logic              lft_wr,
   input logic [IDX_W-1:0]  lft_idx,
   input logic [DATA_W-1:0] lft_wdata,
   input logic [DATA_W-1:0] lft_rdata,
   input logic              rgt_sem_sel,
   input logic              rgt_mem_en,
   input logic              rgt_wr,
   input logic [IDX_W-1:0]  rgt_idx,
   input logic [DATA_W-1:0] rgt_wdata,
   input logic [DATA_W-1:0] rgt_rdata,
   input logic [N_FLAGS-1:0] own_l_q,
   input logic [N_FLAGS-1:0] own_r_q,
   input logic [N_FLAGS-1:0] pend_l_q,
   input logic [N_FLAGS-1:0] pend_r_q
);
   logic l_ok, r_ok, l_wr, r_wr, l_rd, r_rd;
   assign l_ok = lft_sem_sel && !lft_mem_en;
   assign r_ok = rgt_sem_sel && !rgt_mem_en;
   assign l_wr = l_ok && lft_wr;
   assign r_wr = r_ok && rgt_wr;
   assign l_rd = l_ok && !lft_wr;
   assign r_rd = r_ok && !rgt_wr;

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l_q & own_r_q) == '0); // R8

   AST_LFT_RD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      l_rd |=> lft_rdata == {DATA_W{~$past(own_l_q[lft_idx])}}); // R3

   AST_RGT_RD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      r_rd |=> rgt_rdata == {DATA_W{~$past(own_r_q[rgt_idx])}}); // R10

   AST_LFT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (l_wr && !lft_wdata[0] && !own_r_q[lft_idx] && !r_wr) |=> own_l_q[$past(lft_idx)]); // R5

   AST_LFT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (l_wr && lft_wdata[0]) |=> (!own_l_q[$past(lft_idx)] && !pend_l_q[$past(lft_idx)])); // R7

   AST_RGT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (r_wr && rgt_wdata[0]) |=> (!own_r_q[$past(rgt_idx)] && !pend_r_q[$past(rgt_idx)])); // R10

   AST_GATED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_ok && !r_ok) |=> ($stable(own_l_q) && $stable(own_r_q) && $stable(pend_l_q)
                            && $stable(pend_r_q) && $stable(lft_rdata) && $stable(rgt_rdata))); // R4
endmodule

bind dpsem_unit dpsem_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LEFT_WINS(LEFT_WINS)) i_chk (.*);

// File: tb/test_dpsem_unit.sv
module test_dpsem_unit;
   localparam int CLK_P = 10;
   localparam logic [15:0] ONES  = 16'hFFFF;
   localparam logic [15:0] ZEROS = 16'h0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic        lft_sem_sel = 0, lft_mem_en = 0, lft_wr = 0;
   logic [2:0]  lft_idx = 0;
   logic [15:0] lft_wdata = 0;
   logic [15:0] lft_rdata;
   logic        rgt_sem_sel = 0, rgt_mem_en = 0, rgt_wr = 0;
   logic [2:0]  rgt_idx = 0;
   logic [15:0] rgt_wdata = 0;
   logic [15:0] rgt_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   dpsem_unit i_dpsem_unit (.*);

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      lft_sem_sel = 0; lft_mem_en = 0; lft_wr = 0; lft_wdata = 0;
      rgt_sem_sel = 0; rgt_mem_en = 0; rgt_wr = 0; rgt_wdata = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic wr_l(input logic [2:0] i, input logic [15:0] d);
      lft_sem_sel = 1; lft_wr = 1; lft_idx = i; lft_wdata = d;
      tick();
   endtask

   task automatic wr_r(input logic [2:0] i, input logic [15:0] d);
      rgt_sem_sel = 1; rgt_wr = 1; rgt_idx = i; rgt_wdata = d;
      tick();
   endtask

   task automatic rd_both(input logic [2:0] li, input logic [2:0] ri);
      lft_sem_sel = 1; lft_wr = 0; lft_idx = li;
      rgt_sem_sel = 1; rgt_wr = 0; rgt_idx = ri;
      tick();
   endtask

   task automatic t_reset();
      check("R9 left rdata after reset", lft_rdata, ONES);
      check("R9 right rdata after reset", rgt_rdata, ONES);
      for (int k = 0; k < 8; k++) begin
         rd_both(3'(k), 3'(7 - k));
         check("R9 left flag free", lft_rdata, ONES);
         check("R9 right flag free", rgt_rdata, ONES);
      end
   endtask

   task automatic t_grant_left();
      wr_l(3'd2, 16'h0000);
      rd_both(3'd2, 3'd2);
      check("R5 R3 left owns flag 2", lft_rdata, ZEROS);
      check("R3 right sees flag 2 taken", rgt_rdata, ONES);
      rd_both(3'd3, 3'd3);
      check("R1 left flag 3 untouched", lft_rdata, ONES);
      check("R1 right flag 3 untouched", rgt_rdata, ONES);
   endtask

   task automatic t_bit0_right();
      wr_r(3'd5, 16'hFFFE);
      rd_both(3'd5, 3'd5);
      check("R2 R10 right owns flag 5 with upper bits set", rgt_rdata, ZEROS);
      check("R10 left sees flag 5 taken", lft_rdata, ONES);
      wr_r(3'd5, 16'h0001);
      rd_both(3'd5, 3'd5);
      check("R7 right released flag 5", rgt_rdata, ONES);
      check("R7 left sees flag 5 free", lft_rdata, ONES);
   endtask

   task automatic t_pending();
      wr_r(3'd2, 16'h0000);
      rd_both(3'd2, 3'd2);
      check("R6 right request pending", rgt_rdata, ONES);
      check("R6 left still owns", lft_rdata, ZEROS);
      wr_l(3'd2, 16'h0001);
      rd_both(3'd2, 3'd2);
      check("R6 right granted on release", rgt_rdata, ZEROS);
      check("R6 left no longer owns", lft_rdata, ONES);
   endtask

   task automatic t_cancel();
      wr_l(3'd2, 16'h0000);
      wr_l(3'd2, 16'h0001);
      wr_r(3'd2, 16'h0001);
      rd_both(3'd2, 3'd2);
      check("R7 cancelled request not granted", lft_rdata, ONES);
      check("R7 right released flag 2", rgt_rdata, ONES);
   endtask

   task automatic t_contention();
      lft_sem_sel = 1; lft_wr = 1; lft_idx = 3'd6; lft_wdata = 16'h0000;
      rgt_sem_sel = 1; rgt_wr = 1; rgt_idx = 3'd6; rgt_wdata = 16'h0000;
      tick();
      rd_both(3'd6, 3'd6);
      check("R8 left wins tie", lft_rdata, ZEROS);
      check("R8 right loses tie", rgt_rdata, ONES);
      wr_l(3'd6, 16'h0001);
      rd_both(3'd6, 3'd6);
      check("R8 loser pending then granted", rgt_rdata, ZEROS);
      check("R8 left free after release", lft_rdata, ONES);
      wr_r(3'd6, 16'h0001);
   endtask

   task automatic t_gating();
      lft_sem_sel = 1; lft_mem_en = 1; lft_wr = 1; lft_idx = 3'd1; lft_wdata = 0;
      tick();
      lft_sem_sel = 0; lft_wr = 1; lft_idx = 3'd1; lft_wdata = 0;
      tick();
      rd_both(3'd1, 3'd1);
      check("R4 blocked writes grant nothing", lft_rdata, ONES);
      wr_l(3'd1, 16'h0000);
      rd_both(3'd1, 3'd1);
      check("R4 valid write grants flag 1", lft_rdata, ZEROS);
      lft_sem_sel = 1; lft_mem_en = 1; lft_wr = 0; lft_idx = 3'd0;
      tick();
      check("R4 blocked read leaves rdata", lft_rdata, ZEROS);
      wr_l(3'd1, 16'h0001);
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_grant_left();
      t_bit0_right();
      t_pending();
      t_cancel();
      t_contention();
      t_gating();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule